// File: doc/BRIEF.md
# Layer-Quorum Associative Pattern Matcher

The block holds a set of track patterns, each made of one hit word per detector layer. During an event, hits arrive as a stream of (layer, value) pairs. Every hit is compared in the same cycle with the word stored on that layer in every pattern. A match sets a per-pattern, per-layer flag, and that flag stays set until the event is closed.

When the end-of-event strobe is accepted, the flags freeze. For each pattern, the number of layers with a set flag is compared with a threshold taken at that strobe. An encoder then lists the addresses of the passing patterns, lowest address first, one address per cycle. A done pulse marks the end of the list. On that same edge all flags clear and the block is ready for the next event.

Patterns are loaded through a write port, one layer word per cycle. The write port is accepted only before the first hit of an event.

Top module: `am_matcher`

## Requirements
- R1: After reset, `rd_valid` and `rd_done` are 0, `hit_ready` is 1, and every stored word and flag is 0.
- R2: A write (`wr_en`=1) stores `wr_data` as the word of pattern `wr_pat` on layer `wr_layer` only while no hit has been accepted since the last clear and no readout is running. A write at any other time has no effect.
- R3: An accepted hit (`hit_valid`=1 and `hit_ready`=1) sets the flag of every pattern whose word on layer `hit_layer` equals `hit_value`. The flag holds until the clear at the end of readout.
- R4: A layer that matches several times in one event adds exactly one to its pattern's matched-layer count.
- R5: A pattern passes when its matched-layer count is greater than or equal to the threshold. The threshold is `threshold` sampled on the edge where `eoe` is accepted. A value of 0 is treated as 1, and a value above the number of layers is treated as the number of layers.
- R6: Passing addresses appear on `rd_addr` with `rd_valid`=1 in strictly ascending order, one per cycle, with no gaps. The first address appears on the second edge after the edge that accepted `eoe`.
- R7: `rd_done` is a single-cycle pulse on the edge after the last address. If no pattern passes, it comes on the second edge after `eoe` is accepted. `rd_valid` is 0 while `rd_done` is 1.
- R8: `hit_ready` is 0 from the edge that accepts `eoe` until the edge that raises `rd_done`. Hits presented in that window are ignored.
- R9: On the `rd_done` edge all flags clear and `hit_ready` returns to 1, so the next event starts with no matches.
- R10: A hit accepted on the same edge as `eoe` belongs to the event being closed and counts in its quorum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Pattern word write strobe |
| wr_pat | input | PAW | Pattern address to write |
| wr_layer | input | LW | Layer of the word to write |
| wr_data | input | HIT_WIDTH | Word value |
| hit_valid | input | 1 | Hit present |
| hit_ready | output | 1 | Block accepts hits and end of event |
| hit_layer | input | LW | Layer of the hit |
| hit_value | input | HIT_WIDTH | Hit value |
| eoe | input | 1 | End of event, accepted while `hit_ready` is 1 |
| threshold | input | CW | Matched-layer quorum, sampled with `eoe` |
| rd_valid | output | 1 | `rd_addr` carries a passing pattern |
| rd_addr | output | PAW | Address of a passing pattern |
| rd_done | output | 1 | End-of-readout pulse |

## Verification
The last hit of an event and the end-of-event strobe can arrive on the same edge. The hit must then reach the flags that the quorum reads. The bench provokes this by completing a pattern with its final layer hit in the strobe cycle, and it checks that this pattern is listed only because of that hit. Two other overlaps are also provoked and judged against the bench model: a write issued after the first hit, and hits held valid through the whole readout.

// File: rtl/am_pkg.sv
package am_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_READ  = 2'd2
    } am_state_e;
endpackage

// File: rtl/am_pattern_store.sv
module am_pattern_store #(
    parameter int NP  = 16,
    parameter int NL  = 8,
    parameter int HW  = 16,
    parameter int PAW = 4,
    parameter int LW  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [PAW-1:0]         wr_pat_i,
    input  logic [LW-1:0]          wr_layer_i,
    input  logic [HW-1:0]          wr_data_i,
    input  logic                   hit_en_i,
    input  logic [LW-1:0]          hit_layer_i,
    input  logic [HW-1:0]          hit_value_i,
    input  logic                   clear_i,
    output logic [NP-1:0][NL-1:0]  flags_o
);
    typedef struct packed {
        logic [NP-1:0][NL-1:0][HW-1:0] mem;
        logic [NP-1:0][NL-1:0]         flags;
    } store_t;

    store_t st_d, st_q;
    logic [NP-1:0][NL-1:0] hit_eq;

    // one comparator per stored word, all working on the same hit
    for (genvar p = 0; p < NP; p++) begin : g_pat
        for (genvar l = 0; l < NL; l++) begin : g_lay
            assign hit_eq[p][l] = hit_en_i && (int'(hit_layer_i) == l)
                                  && (st_q.mem[p][l] == hit_value_i);
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_en_i && (int'(wr_pat_i) < NP) && (int'(wr_layer_i) < NL)) begin
            st_d.mem[wr_pat_i][wr_layer_i] = wr_data_i;
        end
        for (int p = 0; p < NP; p++) begin
            for (int l = 0; l < NL; l++) begin
                if (clear_i) begin
                    st_d.flags[p][l] = 1'b0;
                end else if (hit_eq[p][l]) begin
                    st_d.flags[p][l] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/am_quorum.sv
module am_quorum #(
    parameter int NP = 16,
    parameter int NL = 8,
    parameter int CW = 4
) (
    input  logic [NP-1:0][NL-1:0] flags_i,
    input  logic [CW-1:0]         thr_i,
    output logic [NP-1:0]         pass_o
);
    for (genvar p = 0; p < NP; p++) begin : g_cnt
        logic [CW-1:0] layer_cnt;
        always_comb begin
            layer_cnt = '0;
            for (int l = 0; l < NL; l++) begin
                layer_cnt = layer_cnt + CW'(flags_i[p][l]);
            end
        end
        assign pass_o[p] = (layer_cnt >= thr_i);
    end
endmodule

// File: rtl/am_readout_enc.sv
module am_readout_enc #(
    parameter int NP  = 16,
    parameter int PAW = 4
) (
    input  logic [NP-1:0]  req_i,
    output logic           any_o,
    output logic [PAW-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = NP - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = PAW'(i);
            end
        end
    end
endmodule

// File: rtl/am_matcher.sv
module am_matcher #(
    parameter int NUM_PATTERNS = 16,
    parameter int NUM_LAYERS   = 8,
    parameter int HIT_WIDTH    = 16,
    localparam int PAW = (NUM_PATTERNS > 1) ? $clog2(NUM_PATTERNS) : 1,
    localparam int LW  = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1,
    localparam int CW  = $clog2(NUM_LAYERS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PAW-1:0]       wr_pat,
    input  logic [LW-1:0]        wr_layer,
    input  logic [HIT_WIDTH-1:0] wr_data,
    input  logic                 hit_valid,
    output logic                 hit_ready,
    input  logic [LW-1:0]        hit_layer,
    input  logic [HIT_WIDTH-1:0] hit_value,
    input  logic                 eoe,
    input  logic [CW-1:0]        threshold,
    output logic                 rd_valid,
    output logic [PAW-1:0]       rd_addr,
    output logic                 rd_done
);
    import am_pkg::*;

    typedef struct packed {
        am_state_e               state;
        logic [CW-1:0]           thr;
        logic [NUM_PATTERNS-1:0] served;
        logic                    rd_valid;
        logic [PAW-1:0]          rd_addr;
        logic                    rd_done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_PATTERNS-1:0][NUM_LAYERS-1:0] flags;
    logic [NUM_PATTERNS-1:0] pass;
    logic [NUM_PATTERNS-1:0] pending;
    logic                    enc_any;
    logic [PAW-1:0]          enc_idx;
    logic                    hit_fire;
    logic                    wr_fire;
    logic                    clear;
    logic [CW-1:0]           thr_clamped;

    assign hit_ready = (ctl_q.state != ST_READ);
    assign hit_fire  = hit_valid && hit_ready;
    assign wr_fire   = wr_en && (ctl_q.state == ST_IDLE);
    assign pending   = pass & ~ctl_q.served;

    always_comb begin
        if (threshold == '0) begin
            thr_clamped = CW'(1);
        end else if (int'(threshold) > NUM_LAYERS) begin
            thr_clamped = CW'(NUM_LAYERS);
        end else begin
            thr_clamped = threshold;
        end
    end

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.rd_valid = 1'b0;
        ctl_d.rd_done  = 1'b0;
        clear          = 1'b0;
        case (ctl_q.state)
            ST_IDLE, ST_ACCUM: begin
                if (hit_fire) begin
                    ctl_d.state = ST_ACCUM;
                end
                if (eoe) begin
                    ctl_d.state  = ST_READ;
                    ctl_d.thr    = thr_clamped;
                    ctl_d.served = '0;
                end
            end
            ST_READ: begin
                if (enc_any) begin
                    ctl_d.rd_valid        = 1'b1;
                    ctl_d.rd_addr         = enc_idx;
                    ctl_d.served[enc_idx] = 1'b1;
                end else begin
                    ctl_d.rd_done = 1'b1;
                    ctl_d.state   = ST_IDLE;
                    ctl_d.served  = '0;
                    clear         = 1'b1;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    am_pattern_store #(
        .NP (NUM_PATTERNS),
        .NL (NUM_LAYERS),
        .HW (HIT_WIDTH),
        .PAW(PAW),
        .LW (LW)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_fire),
        .wr_pat_i   (wr_pat),
        .wr_layer_i (wr_layer),
        .wr_data_i  (wr_data),
        .hit_en_i   (hit_fire),
        .hit_layer_i(hit_layer),
        .hit_value_i(hit_value),
        .clear_i    (clear),
        .flags_o    (flags)
    );

    am_quorum #(
        .NP(NUM_PATTERNS),
        .NL(NUM_LAYERS),
        .CW(CW)
    ) u_quorum (
        .flags_i(flags),
        .thr_i  (ctl_q.thr),
        .pass_o (pass)
    );

    am_readout_enc #(
        .NP (NUM_PATTERNS),
        .PAW(PAW)
    ) u_enc (
        .req_i(pending),
        .any_o(enc_any),
        .idx_o(enc_idx)
    );

    assign rd_valid = ctl_q.rd_valid;
    assign rd_addr  = ctl_q.rd_addr;
    assign rd_done  = ctl_q.rd_done;
endmodule

// File: rtl/am_matcher_chk.sv
module am_matcher_chk #(
    parameter int NUM_PATTERNS = 16,
    parameter int PAW          = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hit_ready,
    input logic           eoe,
    input logic           rd_valid,
    input logic [PAW-1:0] rd_addr,
    input logic           rd_done
);
    p_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid)) |-> (rd_addr > $past(rd_addr)));

    p_addr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (int'(rd_addr) < NUM_PATTERNS));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_done && rd_valid));

    p_eoe_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ready && eoe) |=> !hit_ready);

    p_busy_while_listing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !hit_ready);

    p_ready_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> hit_ready);
endmodule

bind am_matcher am_matcher_chk #(
    .NUM_PATTERNS(NUM_PATTERNS),
    .PAW         (PAW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_ready(hit_ready),
    .eoe      (eoe),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .rd_done  (rd_done)
);

// File: tb/am_matcher_tb.sv
module am_matcher_tb;
    localparam int NP  = 16;
    localparam int NL  = 8;
    localparam int HW  = 16;
    localparam int PAW = 4;
    localparam int LW  = 3;
    localparam int CW  = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [PAW-1:0] wr_pat;
    logic [LW-1:0] wr_layer;
    logic [HW-1:0] wr_data;
    logic          hit_valid;
    logic          hit_ready;
    logic [LW-1:0] hit_layer;
    logic [HW-1:0] hit_value;
    logic          eoe;
    logic [CW-1:0] threshold;
    logic          rd_valid;
    logic [PAW-1:0] rd_addr;
    logic          rd_done;

    int checks = 0;
    int errors = 0;

    logic [HW-1:0] mdl_mem  [NP][NL];
    bit            mdl_flag [NP][NL];
    bit            ev_open = 1'b0;

    always #2.5 clk = ~clk;

    am_matcher #(.NUM_PATTERNS(NP), .NUM_LAYERS(NL), .HIT_WIDTH(HW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_pat(wr_pat), .wr_layer(wr_layer), .wr_data(wr_data),
        .hit_valid(hit_valid), .hit_ready(hit_ready),
        .hit_layer(hit_layer), .hit_value(hit_value),
        .eoe(eoe), .threshold(threshold),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_done(rd_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clamp_thr(input int t);
        if (t < 1) return 1;
        if (t > NL) return NL;
        return t;
    endfunction

    function automatic void model_hit(input int l, input logic [HW-1:0] v);
        for (int p = 0; p < NP; p++) begin
            if (mdl_mem[p][l] == v) mdl_flag[p][l] = 1'b1;
        end
    endfunction

    task automatic do_write(input int p, input int l, input logic [HW-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_pat = PAW'(p); wr_layer = LW'(l); wr_data = v;
        if (!ev_open) mdl_mem[p][l] = v;  // R2: ignored once an event is open
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_hit(input int l, input logic [HW-1:0] v);
        bit acc;
        @(negedge clk);
        acc = hit_ready;
        hit_valid = 1'b1; hit_layer = LW'(l); hit_value = v;
        @(negedge clk);
        hit_valid = 1'b0;
        if (acc) begin
            model_hit(l, v);
            ev_open = 1'b1;
        end
    endtask

    task automatic end_event(input int thr, input bit with_hit, input int hl,
                             input logic [HW-1:0] hv, input bit inject);
        int exp_q[$];
        int t;
        int cnt;
        @(negedge clk);
        eoe = 1'b1; threshold = CW'(thr);
        if (with_hit) begin
            hit_valid = 1'b1; hit_layer = LW'(hl); hit_value = hv;
            model_hit(hl, hv);  // R10: hit on the eoe edge belongs to this event
        end
        t = clamp_thr(thr);
        for (int p = 0; p < NP; p++) begin
            int c = 0;
            for (int l = 0; l < NL; l++) c += int'(mdl_flag[p][l]);
            if (c >= t) exp_q.push_back(p);
        end
        cnt = exp_q.size();
        @(negedge clk);
        eoe = 1'b0; hit_valid = 1'b0;
        check(!rd_valid && !rd_done, "R6 quiet first read cycle", int'(rd_valid), 0);
        check(!hit_ready, "R8 ready low after eoe", int'(hit_ready), 0);
        if (inject) begin
            hit_valid = 1'b1; hit_layer = '0; hit_value = mdl_mem[0][0];
        end
        for (int i = 0; i <= cnt; i++) begin
            @(negedge clk);
            if (i < cnt) begin
                check(rd_valid && !rd_done, "R6 valid in slot", int'(rd_valid), 1);
                check(int'(rd_addr) == exp_q[i], "R6 address order", int'(rd_addr), exp_q[i]);
                check(!hit_ready, "R8 ready low in readout", int'(hit_ready), 0);
            end else begin
                check(rd_done && !rd_valid, "R7 done after last", int'(rd_done), 1);
            end
        end
        hit_valid = 1'b0;
        @(negedge clk);
        check(!rd_done, "R7 done is one cycle", int'(rd_done), 0);
        check(hit_ready, "R9 ready after done", int'(hit_ready), 1);
        for (int p = 0; p < NP; p++)
            for (int l = 0; l < NL; l++) mdl_flag[p][l] = 1'b0;
        ev_open = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        rst_n = 1'b0; wr_en = 1'b0; wr_pat = '0; wr_layer = '0; wr_data = '0;
        hit_valid = 1'b0; hit_layer = '0; hit_value = '0; eoe = 1'b0; threshold = '0;
        for (int p = 0; p < NP; p++)
            for (int l = 0; l < NL; l++) begin
                mdl_mem[p][l] = '0; mdl_flag[p][l] = 1'b0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!rd_valid && !rd_done, "R1 outputs after reset", int'(rd_valid), 0);
        check(hit_ready, "R1 ready after reset", int'(hit_ready), 1);
        rst_n = 1'b1;

        // R1: all words zero, so a zero hit on layer 0 matches every pattern
        send_hit(0, '0);
        end_event(1, 1'b0, 0, '0, 1'b0);

        // R2: distinct contents
        for (int p = 0; p < NP; p++)
            for (int l = 0; l < NL; l++) do_write(p, l, HW'(p * 16 + l));

        // R3: full match of one pattern
        for (int l = 0; l < NL; l++) send_hit(l, HW'(5 * 16 + l));
        end_event(8, 1'b0, 0, '0, 1'b0);

        // R4: repeated layer counted once, nothing passes at 2
        repeat (3) send_hit(0, HW'(2 * 16));
        end_event(2, 1'b0, 0, '0, 1'b0);

        // R5: threshold clamps low and high
        for (int l = 0; l < NL; l++) send_hit(l, HW'(7 * 16 + l));
        for (int l = 0; l < 3; l++) send_hit(l, HW'(9 * 16 + l));
        end_event(0, 1'b0, 0, '0, 1'b0);
        for (int l = 0; l < NL; l++) send_hit(l, HW'(7 * 16 + l));
        for (int l = 0; l < 3; l++) send_hit(l, HW'(9 * 16 + l));
        end_event(15, 1'b0, 0, '0, 1'b0);

        // R2: write after the first hit is ignored, later write while idle lands
        send_hit(1, HW'(1 * 16 + 1));
        do_write(3, 0, 16'hBEEF);
        end_event(8, 1'b0, 0, '0, 1'b0);
        send_hit(0, 16'hBEEF);
        end_event(1, 1'b0, 0, '0, 1'b0);
        do_write(3, 0, 16'hBEEF);
        send_hit(0, 16'hBEEF);
        end_event(1, 1'b0, 0, '0, 1'b0);

        // R10: last layer arrives with eoe
        for (int l = 0; l < NL - 1; l++) send_hit(l, HW'(4 * 16 + l));
        end_event(8, 1'b1, NL - 1, HW'(4 * 16 + NL - 1), 1'b0);

        // R8 and R9: hits during readout are ignored, flags clear afterwards
        send_hit(0, HW'(6 * 16));
        end_event(1, 1'b0, 0, '0, 1'b1);
        end_event(1, 1'b0, 0, '0, 1'b0);

        // random events over a small value alphabet
        for (int p = 0; p < NP; p++)
            for (int l = 0; l < NL; l++) do_write(p, l, HW'($urandom_range(3)));
        for (int e = 0; e < 40; e++) begin
            int nh = int'($urandom_range(12));
            if ($urandom_range(3) == 0)
                do_write(int'($urandom_range(NP - 1)), int'($urandom_range(NL - 1)),
                         HW'($urandom_range(3)));
            for (int h = 0; h < nh; h++)
                send_hit(int'($urandom_range(NL - 1)), HW'($urandom_range(3)));
            if (nh > 0 && $urandom_range(2) == 0)
                do_write(int'($urandom_range(NP - 1)), int'($urandom_range(NL - 1)),
                         HW'($urandom_range(3)));
            end_event(int'($urandom_range(9)), bit'($urandom_range(1)),
                      int'($urandom_range(NL - 1)), HW'($urandom_range(3)),
                      bit'($urandom_range(1)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule